// File: doc/BRIEF.md
# Per-Container VLIW Header Action Engine

This block is the execution half of one match-action stage in a packet pipeline. It receives a 512-bit packet header vector, a very-long instruction word holding one 27-bit instruction per container, and a 128-bit action-data word from the match stage. It returns the updated header vector two clock cycles later. The header vector has four kinds of container: eight of 8 bits, eight of 16 bits, eight of 32 bits, and one 64-bit metadata container. Each container has its own ALU lane, 25 in all. Every lane writes its result only into its own container, so an instruction has no destination field, and all containers can change in the same pass.

The vector is laid out as follows. The 8-bit containers sit at bits [63:0], container k at [8k+7:8k]. The 16-bit containers sit at [191:64], the 32-bit containers at [447:192], and the metadata container at [511:448]. Lanes are numbered 0..7 for the 8-bit containers, 8..15 for the 16-bit ones, 16..23 for the 32-bit ones and 24 for the metadata container. The instruction for lane l occupies bits [27l+26:27l] of the instruction word.

A new vector can enter on every cycle. A valid flag travels alongside each vector.

Top module: `hv_action_engine`

## Requirements
- R1: `valid_o` equals `valid_i` from two rising edges earlier. When that flag is set, `phv_o` is the result for the vector presented then. Vectors may arrive on consecutive cycles.
- R2: A lane keeps its container unchanged in three cases: its instruction is all zero, its low five opcode bits are zero, or its low five opcode bits are an unlisted value (15 to 31).
- R3: Instruction fields are as follows. Bits [26:21] hold the opcode, and opcode bit 5 is the action-data select. Bits [20:16] hold the first operand code. Bits [15:11] hold the second operand code in register forms. Bits [15:0] hold the immediate.
- R4: An operand code is built from a type in bits [4:3] and a position in bits [2:0]. Types 00, 01 and 10 pick the 8-, 16- and 32-bit container at that position. Type 11 picks the metadata container whatever the position.
- R5: Opcodes 1 (add), 2 (sub), 3 (add immediate) and 4 (sub immediate) compute operand1 ± operand2. Operands are zero-extended, and the result is truncated to the lane width, so arithmetic wraps.
- R6: Opcode 6 writes operand1 OR operand2 and opcode 7 writes operand1 XOR operand2. Both operands are container codes.
- R7: Opcodes 8 and 9 shift operand1 left and right by the value of a second container. Opcodes 10 and 11 shift by the immediate. A shift amount at or beyond the source width gives zero.
- R8: Opcode 5 writes the immediate, truncated to the lane width.
- R9: When opcode bit 5 is set, the immediate is replaced by a 16-bit slice of the action data. Slice k is bits [16k+15:16k], where k is taken from immediate bits [2:0].
- R10: Opcode 12 writes the lane's own container minus one, modulo its width.
- R11: Opcode 13 on lane 24 writes immediate bits [7:0] into metadata bits [15:8] and keeps all other bits. On any other lane it has no effect.
- R12: Opcode 14 on lane 24 sets metadata bit 0, the drop flag, and keeps all other bits. On any other lane it has no effect.
- R13: A lane never alters any container other than its own.
- R14: While `rst_ni` is low, `valid_o` and `phv_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vector is valid |
| phv_i | input | 512 | Input header vector |
| vliw_i | input | 675 | 25 lane instructions of 27 bits each |
| ad_i | input | 128 | Action data from the match stage |
| valid_o | output | 1 | Output vector is valid |
| phv_o | output | 512 | Updated header vector |

## Verification
Directed vectors each exercise one opcode on chosen lanes, using values that expose specific errors:
- An 8-bit add of 0xFF and 1 exposes missing wrap-around.
- A 16-bit lane fed from a 32-bit and an 8-bit container exposes wrong type decoding or wrong truncation.
- A 32-bit subtract read from the metadata container with a nonzero position field exposes index misuse on type 11.
- A right shift by 40 exposes wrong handling of oversize shift amounts.
- The port-set and drop opcodes are run on both the metadata lane and an ordinary lane. This separates lane-specific behaviour from a shared decoder.

Random instruction words then mix all opcodes, unlisted values and random operand codes across every lane at once, with occasional bubbles. This catches cross-lane leakage and latency or valid misalignment, which single-lane vectors cannot show.

// File: rtl/hv_pkg.sv
package hv_pkg;
  localparam int CNT_PER_TYPE = 8;
  localparam int W8   = 8;
  localparam int W16  = 16;
  localparam int W32  = 32;
  localparam int W64  = 64;
  localparam int N_LANES = 3 * CNT_PER_TYPE + 1;
  localparam int OFF16 = CNT_PER_TYPE * W8;
  localparam int OFF32 = OFF16 + CNT_PER_TYPE * W16;
  localparam int OFF64 = OFF32 + CNT_PER_TYPE * W32;
  localparam int PHV_W = OFF64 + W64;

  localparam int OPC_W  = 6;
  localparam int ALU_W  = OPC_W - 1;
  localparam int CODE_W = 5;
  localparam int IMM_W  = 16;
  localparam int INS_W  = OPC_W + CODE_W + IMM_W;
  localparam int VLIW_W = N_LANES * INS_W;
  localparam int AD_W   = 128;
  localparam int AD_SLICES = AD_W / IMM_W;
  localparam int SEL_W  = $clog2(AD_SLICES);

  localparam logic [ALU_W-1:0] OP_ADD  = 5'd1;
  localparam logic [ALU_W-1:0] OP_SUB  = 5'd2;
  localparam logic [ALU_W-1:0] OP_ADDI = 5'd3;
  localparam logic [ALU_W-1:0] OP_SUBI = 5'd4;
  localparam logic [ALU_W-1:0] OP_SET  = 5'd5;
  localparam logic [ALU_W-1:0] OP_OR   = 5'd6;
  localparam logic [ALU_W-1:0] OP_XOR  = 5'd7;
  localparam logic [ALU_W-1:0] OP_SHL  = 5'd8;
  localparam logic [ALU_W-1:0] OP_SHR  = 5'd9;
  localparam logic [ALU_W-1:0] OP_SHLI = 5'd10;
  localparam logic [ALU_W-1:0] OP_SHRI = 5'd11;
  localparam logic [ALU_W-1:0] OP_DEC  = 5'd12;
  localparam logic [ALU_W-1:0] OP_PORT = 5'd13;
  localparam logic [ALU_W-1:0] OP_DROP = 5'd14;

  function automatic int lane_width(input int l);
    if (l < CNT_PER_TYPE)          return W8;
    else if (l < 2 * CNT_PER_TYPE) return W16;
    else if (l < 3 * CNT_PER_TYPE) return W32;
    else                           return W64;
  endfunction

  function automatic int lane_base(input int l);
    if (l < CNT_PER_TYPE)          return l * W8;
    else if (l < 2 * CNT_PER_TYPE) return OFF16 + (l - CNT_PER_TYPE) * W16;
    else if (l < 3 * CNT_PER_TYPE) return OFF32 + (l - 2 * CNT_PER_TYPE) * W32;
    else                           return OFF64;
  endfunction

  // type in [4:3], position in [2:0]; type 11 ignores position
  function automatic logic [W64-1:0] read_code(input logic [PHV_W-1:0] phv,
                                               input logic [CODE_W-1:0] code);
    int idx;
    idx = int'(code[2:0]);
    case (code[4:3])
      2'b00:   return W64'(phv[idx*W8 +: W8]);
      2'b01:   return W64'(phv[OFF16 + idx*W16 +: W16]);
      2'b10:   return W64'(phv[OFF32 + idx*W32 +: W32]);
      default: return phv[OFF64 +: W64];
    endcase
  endfunction
endpackage

// File: rtl/hv_src_fetch.sv
module hv_src_fetch
  import hv_pkg::*;
(
  input  logic [PHV_W-1:0] phv_i,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [INS_W-1:0] ins_i,
  output logic [ALU_W-1:0] op_o,
  output logic [W64-1:0]   a_o,
  output logic [W64-1:0]   b_o
);
  logic [OPC_W-1:0]  opc;
  logic [IMM_W-1:0]  imm;
  logic [SEL_W-1:0]  sel;
  logic              reg_form;

  assign opc  = ins_i[INS_W-1 -: OPC_W];
  assign op_o = opc[ALU_W-1:0];
  assign sel  = ins_i[SEL_W-1:0];
  assign imm  = opc[OPC_W-1] ? ad_i[int'(sel)*IMM_W +: IMM_W] : ins_i[IMM_W-1:0];

  always_comb begin
    reg_form = (op_o == OP_ADD) || (op_o == OP_SUB) || (op_o == OP_OR) ||
               (op_o == OP_XOR) || (op_o == OP_SHL) || (op_o == OP_SHR);
    a_o = read_code(phv_i, ins_i[IMM_W +: CODE_W]);
    b_o = reg_form ? read_code(phv_i, ins_i[IMM_W-1 -: CODE_W]) : W64'(imm);
  end
endmodule

// File: rtl/hv_lane_alu.sv
module hv_lane_alu
  import hv_pkg::*;
#(
  parameter int W       = 8,
  parameter bit IS_META = 1'b0
) (
  input  logic [ALU_W-1:0] op_i,
  input  logic [W64-1:0]   a_i,
  input  logic [W64-1:0]   b_i,
  input  logic [W-1:0]     own_i,
  output logic [W-1:0]     res_o
);
  logic [W64-1:0] own64;
  logic [W64-1:0] wide;

  assign own64 = W64'(own_i);

  always_comb begin
    case (op_i)
      OP_ADD, OP_ADDI: wide = a_i + b_i;
      OP_SUB, OP_SUBI: wide = a_i - b_i;
      OP_OR:           wide = a_i | b_i;
      OP_XOR:          wide = a_i ^ b_i;
      OP_SHL, OP_SHLI: wide = a_i << b_i;
      OP_SHR, OP_SHRI: wide = a_i >> b_i;
      OP_SET:          wide = b_i;
      OP_DEC:          wide = own64 - W64'(1);
      OP_PORT:         wide = IS_META ? {own64[63:16], b_i[7:0], own64[7:0]} : own64;
      OP_DROP:         wide = IS_META ? (own64 | W64'(1)) : own64;
      default:         wide = own64;
    endcase
    res_o = wide[W-1:0];
  end
endmodule

// File: rtl/hv_action_engine.sv
module hv_action_engine
  import hv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [PHV_W-1:0]  phv_i,
  input  logic [VLIW_W-1:0] vliw_i,
  input  logic [AD_W-1:0]   ad_i,
  output logic              valid_o,
  output logic [PHV_W-1:0]  phv_o
);
  logic             v_s1;
  logic             v_s2;
  logic [PHV_W-1:0] nxt_phv;
  logic [PHV_W-1:0] phv_q;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    localparam int W = lane_width(l);
    localparam int B = lane_base(l);

    logic [ALU_W-1:0] f_op, s_op;
    logic [W64-1:0]   f_a, f_b, s_a, s_b;
    logic [W-1:0]     s_own, res;

    hv_src_fetch u_fetch (
      .phv_i (phv_i),
      .ad_i  (ad_i),
      .ins_i (vliw_i[l*INS_W +: INS_W]),
      .op_o  (f_op),
      .a_o   (f_a),
      .b_o   (f_b)
    );

    // stage 1: operands captured
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_op  <= '0;
        s_a   <= '0;
        s_b   <= '0;
        s_own <= '0;
      end else begin
        s_op  <= f_op;
        s_a   <= f_a;
        s_b   <= f_b;
        s_own <= phv_i[B +: W];
      end
    end

    hv_lane_alu #(.W(W), .IS_META(l == N_LANES - 1)) u_alu (
      .op_i  (s_op),
      .a_i   (s_a),
      .b_i   (s_b),
      .own_i (s_own),
      .res_o (res)
    );

    assign nxt_phv[B +: W] = res;
  end

  // stage 2: results captured
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_s1  <= 1'b0;
      v_s2  <= 1'b0;
      phv_q <= '0;
    end else begin
      v_s1  <= valid_i;
      v_s2  <= v_s1;
      phv_q <= nxt_phv;
    end
  end

  assign valid_o = v_s2;
  assign phv_o   = phv_q;
endmodule

// File: rtl/hv_action_engine_chk.sv
module hv_action_engine_chk
  import hv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [PHV_W-1:0]  phv_i,
  input logic [VLIW_W-1:0] vliw_i,
  input logic              valid_o,
  input logic [PHV_W-1:0]  phv_o
);
  localparam int META_INS = (N_LANES - 1) * INS_W;

  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  assert_nop_keeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && $past(valid_i, 2) && $past(vliw_i, 2) == '0) |-> (phv_o == $past(phv_i, 2)));

  assert_lane0_isolate_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && $past(vliw_i[INS_W-1:0], 2) == '0) |-> (phv_o[W8-1:0] == $past(phv_i[W8-1:0], 2)));

  assert_drop_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && $past(vliw_i[META_INS + INS_W - 1 -: OPC_W], 2) == OPC_W'(14)) |-> phv_o[OFF64]);

  assert_port_field_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2 && $past(vliw_i[META_INS + INS_W - 1 -: OPC_W], 2) == OPC_W'(13))
      |-> (phv_o[OFF64 + 8 +: 8] == $past(vliw_i[META_INS +: 8], 2)));
endmodule

bind hv_action_engine hv_action_engine_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .phv_i   (phv_i),
  .vliw_i  (vliw_i),
  .valid_o (valid_o),
  .phv_o   (phv_o)
);

// File: tb/tb_hv_action_engine.sv
module tb_hv_action_engine;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [511:0] phv_i = '0;
  logic [674:0] vliw_i = '0;
  logic [127:0] ad_i = '0;
  logic         valid_o;
  logic [511:0] phv_o;

  always #4 clk = ~clk;

  hv_action_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .phv_i(phv_i),
    .vliw_i(vliw_i), .ad_i(ad_i), .valid_o(valid_o), .phv_o(phv_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [511:0] e1 = '0, e2 = '0;
  logic         v1 = 1'b0, v2 = 1'b0;
  string        t1 = "R1", t2 = "R1";

  function automatic int lw(input int l);
    return (l < 8) ? 8 : (l < 16) ? 16 : (l < 24) ? 32 : 64;
  endfunction

  function automatic int lb(input int l);
    return (l < 8) ? 8*l : (l < 16) ? 64 + 16*(l-8) : (l < 24) ? 192 + 32*(l-16) : 448;
  endfunction

  function automatic logic [63:0] mask_of(input int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] get(input logic [511:0] p, input int l);
    logic [511:0] s;
    s = p >> lb(l);
    return s[63:0] & mask_of(lw(l));
  endfunction

  function automatic logic [511:0] put(input logic [511:0] p, input int l, input logic [63:0] v);
    logic [511:0] m;
    m = 512'(mask_of(lw(l))) << lb(l);
    return (p & ~m) | (512'(v & mask_of(lw(l))) << lb(l));
  endfunction

  function automatic logic [26:0] ins(input logic [5:0] op, input logic [4:0] c1, input logic [15:0] imm);
    return {op, c1, imm};
  endfunction

  function automatic logic [674:0] place(input logic [674:0] w, input int l, input logic [26:0] i);
    logic [674:0] m;
    m = 675'(27'h7FF_FFFF) << (27*l);
    return (w & ~m) | (675'(i) << (27*l));
  endfunction

  function automatic logic [63:0] src(input logic [511:0] p, input logic [4:0] c);
    if (c[4:3] == 2'b11) return get(p, 24);
    return get(p, int'(c[4:3]) * 8 + int'(c[2:0]));
  endfunction

  function automatic logic [511:0] model(input logic [511:0] p, input logic [674:0] w, input logic [127:0] ad);
    logic [511:0] r;
    r = p;
    for (int l = 0; l < 25; l++) begin
      logic [26:0] i;
      logic [4:0]  op;
      logic [15:0] im;
      logic [63:0] a, b, own, o;
      i   = w[27*l +: 27];
      op  = i[25:21];
      im  = i[26] ? ad[16*int'(i[2:0]) +: 16] : i[15:0];
      a   = src(p, i[20:16]);
      b   = src(p, i[15:11]);
      own = get(p, l);
      o   = own;
      case (op)
        5'd1: o = a + b;
        5'd2: o = a - b;
        5'd3: o = a + 64'(im);
        5'd4: o = a - 64'(im);
        5'd5: o = 64'(im);
        5'd6: o = a | b;
        5'd7: o = a ^ b;
        5'd8: o = a << b;
        5'd9: o = a >> b;
        5'd10: o = a << im;
        5'd11: o = a >> im;
        5'd12: o = own - 64'd1;
        5'd13: if (l == 24) o = {own[63:16], im[7:0], own[7:0]};
        5'd14: if (l == 24) o = own | 64'd1;
        default: o = own;
      endcase
      r = put(r, l, o);
    end
    return r;
  endfunction

  task automatic step(input logic [511:0] p, input logic [674:0] w, input logic [127:0] ad,
                      input logic v, input logic [511:0] exp, input string tag);
    @(negedge clk);
    checks++;
    if (valid_o !== v2) begin
      failures++;
      $display("FAIL %s valid: actual=%0b expected=%0b", t2, valid_o, v2);
    end
    if (v2) begin
      checks++;
      if (phv_o !== e2) begin
        failures++;
        $display("FAIL %s phv: actual=%h expected=%h", t2, phv_o, e2);
      end
    end
    e2 = e1; v2 = v1; t2 = t1;
    e1 = exp; v1 = v; t1 = tag;
    phv_i = p; vliw_i = w; ad_i = ad; valid_i = v;
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [511:0] p, q;
    logic [674:0] w;
    logic [127:0] ad;
    void'($urandom(32'h5EED));
    p = rnd512();
    ad = {$urandom, $urandom, $urandom, $urandom};

    // R14: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || phv_o !== '0) begin
      failures++;
      $display("FAIL R14 reset: actual=%0b/%h expected=0/0", valid_o, phv_o);
    end
    rst_ni = 1'b1;

    // R2: all-zero word
    step(p, '0, ad, 1'b1, p, "R2");

    // R5 R3: 8-bit add wraps
    q = put(put(p, 0, 64'hFF), 1, 64'h01);
    w = place('0, 0, ins(6'd1, 5'b00000, {5'b00001, 11'd0}));
    step(q, w, ad, 1'b1, put(q, 0, 64'h00), "R5");

    // R4: cross-type operands into 16-bit lane
    q = put(put(p, 18, 64'h0001_FFFF), 3, 64'h02);
    w = place('0, 8, ins(6'd1, 5'b10010, {5'b00011, 11'd0}));
    step(q, w, ad, 1'b1, put(q, 8, 64'h0001), "R4");

    // R4 R5: subi from metadata (position ignored)
    q = put(p, 24, 64'h1234_5678_0000_0010);
    w = place('0, 16, ins(6'd4, 5'b11101, 16'h0020));
    step(q, w, ad, 1'b1, put(q, 16, 64'hFFFF_FFF0), "R5");

    // R9 R3: immediate from action-data slice 3
    q = put(p, 9, 64'h0234);
    ad[63:48] = 16'h1000;
    w = place('0, 9, ins(6'h23, 5'b01001, 16'h0003));
    step(q, w, ad, 1'b1, put(q, 9, 64'h1234), "R9");

    // R7: shifts by immediate and by container, oversize gives zero
    q = put(put(put(put(p, 17, 64'h0F00_0001), 2, 64'd40), 19, 64'hDEAD_BEEF), 20, 64'hDEAD_BEEF);
    w = place('0, 17, ins(6'd10, 5'b10001, 16'd4));
    w = place(w, 19, ins(6'd9, 5'b10011, {5'b00010, 11'd0}));
    w = place(w, 20, ins(6'd11, 5'b10100, 16'd8));
    step(q, w, ad, 1'b1, put(put(put(q, 17, 64'hF000_0010), 19, 64'h0), 20, 64'h00DE_ADBE), "R7");

    // R6: or / xor
    q = put(put(put(put(p, 4, 64'hA0), 5, 64'h0B), 6, 64'hFF), 7, 64'h0F);
    w = place('0, 4, ins(6'd6, 5'b00100, {5'b00101, 11'd0}));
    w = place(w, 6, ins(6'd7, 5'b00110, {5'b00111, 11'd0}));
    step(q, w, ad, 1'b1, put(put(q, 4, 64'hAB), 6, 64'hF0), "R6");

    // R8: set immediate, truncated on 8-bit lane
    w = place('0, 10, ins(6'd5, 5'b00000, 16'hBEEF));
    w = place(w, 0, ins(6'd5, 5'b00000, 16'h1234));
    step(p, w, ad, 1'b1, put(put(p, 10, 64'hBEEF), 0, 64'h34), "R8");

    // R10: decrement, wrap from zero
    q = put(put(p, 7, 64'h00), 11, 64'h0040);
    w = place('0, 7, ins(6'd12, 5'b00000, 16'd0));
    w = place(w, 11, ins(6'd12, 5'b00000, 16'd0));
    step(q, w, ad, 1'b1, put(put(q, 7, 64'hFF), 11, 64'h003F), "R10");

    // R11: port on metadata lane and on ordinary lane
    q = put(p, 24, 64'h0123_4567_89AB_CDEF);
    w = place('0, 24, ins(6'd13, 5'b00000, 16'h00A5));
    w = place(w, 1, ins(6'd13, 5'b00000, 16'h00A5));
    step(q, w, ad, 1'b1, put(q, 24, 64'h0123_4567_89AB_A5EF), "R11");

    // R12: drop on metadata lane and on ordinary lane
    q = put(p, 24, 64'hFFFF_0000_0000_0000);
    w = place('0, 24, ins(6'd14, 5'b00000, 16'd0));
    w = place(w, 12, ins(6'd14, 5'b00000, 16'd0));
    step(q, w, ad, 1'b1, put(q, 24, 64'hFFFF_0000_0000_0001), "R12");

    // R2: unlisted opcode and select bit alone
    w = place('0, 21, ins(6'h1F, 5'b10101, 16'hFFFF));
    w = place(w, 22, ins(6'h20, 5'b10110, 16'hFFFF));
    step(p, w, ad, 1'b1, p, "R2");

    // R1: bubble between back-to-back vectors
    step(p, '0, ad, 1'b0, p, "R1");

    // R13 R1: random full-width words, back to back with bubbles
    for (int n = 0; n < 400; n++) begin
      logic [674:0] rw;
      logic         rv;
      q  = rnd512();
      ad = {$urandom, $urandom, $urandom, $urandom};
      rw = '0;
      for (int l = 0; l < 25; l++) begin
        logic [5:0] op;
        op = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 16);
        rw = place(rw, l, {op, 5'($urandom), 16'($urandom)});
      end
      rv = ($urandom % 10) != 0;
      step(q, rw, ad, rv, model(q, rw, ad), "R13");
    end

    step(p, '0, ad, 1'b0, p, "R1");
    step(p, '0, ad, 1'b0, p, "R1");
    step(p, '0, ad, 1'b0, p, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule